// File: doc/BRIEF.md
# Audio Control Register I2C Target

This block lets a host microcontroller program the eight control settings of a stereo tone and volume processor over a two-wire I2C bus. SCL and SDA are oversampled by a fast system clock, passed through synchronisers and turned into START, STOP and clock-edge events. A byte engine then walks through the device address, a register pointer byte and any number of data bytes, writing each data byte into the selected control register. The only bus drive is an open-drain pull-down that the block asserts for acknowledge.

The pointer byte carries a 4-bit register index in bits 3..0 and a step flag in bit 4; bits 7..5 carry no meaning. With the step flag clear every data byte lands in one register; with it set the index advances after each byte and wraps from 15 to 0. Only indices 0 to 7 hold storage. Indices 8 to 15 still take and acknowledge data, which is then discarded. Every register is driven out in parallel, together with decoded mute and illegal-source flags for the analog side.

The controller has eight named states. `ST_IDLE` waits for a START. `ST_ADDR` shifts in the address byte. From there the byte engine takes `ADDR_MATCH` to `ST_ADDR_ACK`, or `ADDR_MISS` to `ST_IGNORE`. `ST_ADDR_ACK` moves to `ST_SUB`, which moves to `ST_SUB_ACK`. That state leads to `ST_DATA`, and `ST_DATA` loops through `ST_DATA_ACK` back to itself. Each acknowledge state is left on the SCL falling edge that closes the ninth clock. A START in any state is `RESTART`, which enters `ST_ADDR`. A STOP in any state is `RELEASE`, which returns to `ST_IDLE`.

Top module: `acp_i2c_target`

## Requirements
- R1: A falling SDA while SCL is high (START) restarts address reception from any state, discarding a partly received byte. A rising SDA while SCL is high (STOP) returns the block to idle, and bus activity in idle changes nothing.
- R2: During the ninth SCL clock after an address byte equal to 0x88, and after every pointer or data byte of that transfer, `sda_pull_o` is 1. It returns to 0 after the SCL falling edge that ends the ninth clock.
- R3: An address byte other than 0x88 (including 0x89, the read form) gets no acknowledge. No register changes and `sda_pull_o` stays 0 until the next START.
- R4: In the pointer byte, bits 3..0 select the register and bit 4 is the step flag. Bits 7..5 have no effect.
- R5: With the step flag 0, every data byte up to the STOP is written to the same register.
- R6: With the step flag 1, the first data byte goes to the sent index and each later one to the next index. The index wraps from 15 to 0.
- R7: Data bytes aimed at indices 8 to 15 change no register but are still acknowledged, and the index still advances through them.
- R8: After reset the registers read, by index 0..7: 0x02 (source 2), 0x0E (gain 28 dB), 0x38 (volume muted), 0x0F (bass flat), 0x0E (middle +2 dB), 0x0E (treble +2 dB), 0x78 and 0x78 (right and left speaker muted).
- R9: `vol_mute_o` is 1 exactly when bits 5..4 of the volume register (index 2) are both 1.
- R10: `spk_r_mute_o` and `spk_l_mute_o` are 1 exactly when bits 6..3 of register 6 and register 7 respectively hold a value of 10 or more.
- R11: `src_sel_bad_o` is 1 exactly when bits 1..0 of the source select register (index 0) are 01, the forbidden code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| src_sel_o | output | 8 | Register 0: source select |
| src_gain_o | output | 8 | Register 1: input gain |
| volume_o | output | 8 | Register 2: volume |
| bass_o | output | 8 | Register 3: bass |
| middle_o | output | 8 | Register 4: middle |
| treble_o | output | 8 | Register 5: treble |
| spk_r_o | output | 8 | Register 6: right speaker attenuation |
| spk_l_o | output | 8 | Register 7: left speaker attenuation |
| vol_mute_o | output | 1 | Volume register decodes to mute |
| spk_r_mute_o | output | 1 | Right attenuation decodes to mute |
| spk_l_mute_o | output | 1 | Left attenuation decodes to mute |
| src_sel_bad_o | output | 1 | Source select holds the forbidden code |

## Verification
The bench drives a pointer of 14 with the step flag set so that the sequence crosses the dropped indices and wraps onto index 0. A design that stalls at index 15 or writes through an aliased index would corrupt registers 0 and 1 or registers 6 and 7. It sends pointer bytes with the upper don't-care bits set, which a decoder using the full byte as index would reject or misplace. It cuts a data byte short with a repeated START and with a STOP, which a design that writes on a bit count alone would commit as a partial byte. It also sends a foreign address and the read form of the right address: a target that acknowledges either, or keeps listening after them, would pull SDA or change a register.

// File: rtl/acp_pkg.sv
package acp_pkg;

    localparam int NUM_CTRL = 8;
    localparam int PTR_W    = 4;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = $clog2(BYTE_W + 1);

    localparam logic [6:0] DEV_ADDR = 7'b1000100;

    localparam int IDX_SRC_SEL  = 0;
    localparam int IDX_SRC_GAIN = 1;
    localparam int IDX_VOLUME   = 2;
    localparam int IDX_BASS     = 3;
    localparam int IDX_MIDDLE   = 4;
    localparam int IDX_TREBLE   = 5;
    localparam int IDX_SPK_R    = 6;
    localparam int IDX_SPK_L    = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } bus_state_e;

    // Power-up setting of each control register
    function automatic logic [BYTE_W-1:0] reset_value(input int idx);
        logic [BYTE_W-1:0] v;
        unique case (idx)
            IDX_SRC_SEL:  v = 8'h02;
            IDX_SRC_GAIN: v = 8'h0E;
            IDX_VOLUME:   v = 8'h38;
            IDX_BASS:     v = 8'h0F;
            IDX_MIDDLE:   v = 8'h0E;
            IDX_TREBLE:   v = 8'h0E;
            IDX_SPK_R:    v = 8'h78;
            default:      v = 8'h78;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/acp_line_sync.sv
module acp_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int LINES = 2;
    localparam int L_SCL = 0;
    localparam int L_SDA = 1;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] pipe [STAGES];
    logic [LINES-1:0] now_v;
    logic [LINES-1:0] last_v;

    assign raw = {sda_i, scl_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                pipe[i] <= '1;
            end
            last_v <= '1;
        end else begin
            pipe[0] <= raw;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
            last_v <= pipe[STAGES-1];
        end
    end

    assign now_v     = pipe[STAGES-1];
    assign sda_q     = now_v[L_SDA];
    assign scl_rise  =  now_v[L_SCL] & ~last_v[L_SCL];
    assign scl_fall  = ~now_v[L_SCL] &  last_v[L_SCL];
    assign start_det =  now_v[L_SCL] &  last_v[L_SCL] &  last_v[L_SDA] & ~now_v[L_SDA];
    assign stop_det  =  now_v[L_SCL] &  last_v[L_SCL] & ~last_v[L_SDA] &  now_v[L_SDA];

endmodule

// File: rtl/acp_bus_fsm.sv
module acp_bus_fsm
    import acp_pkg::*;
#(
    parameter int         DW       = BYTE_W,
    parameter int         PW       = PTR_W,
    parameter logic [6:0] ADDR7    = DEV_ADDR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_q,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    output bus_state_e    state,
    output logic          sda_pull,
    output logic          wr_en,
    output logic [PW-1:0] wr_idx,
    output logic [DW-1:0] wr_data,
    output logic [PW-1:0] ptr,
    output logic          auto_inc
);

    localparam int                 CW        = $clog2(DW + 1);
    localparam logic [CW-1:0]      FULL_CNT  = CW'(DW);
    localparam logic [DW-1:0]      ADDR_BYTE = {ADDR7, 1'b0};

    bus_state_e    nxt;
    logic [DW-1:0] shreg;
    logic [CW-1:0] bit_cnt;
    logic          byte_done;
    logic          addr_hit;
    logic          rx_state;

    assign byte_done = (bit_cnt == FULL_CNT);
    assign addr_hit  = (shreg == ADDR_BYTE);
    assign rx_state  = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_DATA);

    // Next-state logic
    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_ADDR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (scl_fall && byte_done) nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) nxt = ST_SUB;
                ST_SUB:      if (scl_fall && byte_done) nxt = ST_SUB_ACK;
                ST_SUB_ACK:  if (scl_fall) nxt = ST_DATA;
                ST_DATA:     if (scl_fall && byte_done) nxt = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) nxt = ST_DATA;
                ST_IGNORE:   nxt = ST_IGNORE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
            ptr      <= '0;
            auto_inc <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else begin
                if (scl_rise && rx_state && !byte_done) begin
                    shreg   <= {shreg[DW-2:0], sda_q};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (scl_fall) begin
                    unique case (state)
                        ST_ADDR: begin
                            if (byte_done) begin
                                bit_cnt  <= '0;
                                sda_pull <= addr_hit;
                            end
                        end
                        ST_SUB: begin
                            if (byte_done) begin
                                bit_cnt  <= '0;
                                sda_pull <= 1'b1;
                                ptr      <= shreg[PW-1:0];
                                auto_inc <= shreg[PW];
                            end
                        end
                        ST_DATA: begin
                            if (byte_done) begin
                                bit_cnt  <= '0;
                                sda_pull <= 1'b1;
                                wr_en    <= 1'b1;
                                wr_idx   <= ptr;
                                wr_data  <= shreg;
                                if (auto_inc) begin
                                    ptr <= ptr + 1'b1;
                                end
                            end
                        end
                        ST_ADDR_ACK, ST_SUB_ACK, ST_DATA_ACK: begin
                            sda_pull <= 1'b0;
                        end
                        default: begin
                        end
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/acp_ctrl_regs.sv
module acp_ctrl_regs
    import acp_pkg::*;
#(
    parameter int NUM = NUM_CTRL,
    parameter int DW  = BYTE_W,
    parameter int PW  = PTR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] regs_o [NUM]
);

    for (genvar g = 0; g < NUM; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_o[g] <= reset_value(g);
            end else if (wr_en && (wr_idx == PW'(g))) begin
                regs_o[g] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/acp_i2c_target.sv
module acp_i2c_target
    import acp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic [7:0] src_sel_o,
    output logic [7:0] src_gain_o,
    output logic [7:0] volume_o,
    output logic [7:0] bass_o,
    output logic [7:0] middle_o,
    output logic [7:0] treble_o,
    output logic [7:0] spk_r_o,
    output logic [7:0] spk_l_o,
    output logic       vol_mute_o,
    output logic       spk_r_mute_o,
    output logic       spk_l_mute_o,
    output logic       src_sel_bad_o
);

    localparam logic [3:0] SPK_MUTE_MIN = 4'd10;

    logic             sda_q;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    bus_state_e       bus_state;
    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic [PTR_W-1:0] ptr;
    logic             auto_inc;
    logic [BYTE_W-1:0] regs [NUM_CTRL];

    acp_line_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    acp_bus_fsm #(.DW(BYTE_W), .PW(PTR_W), .ADDR7(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .state     (bus_state),
        .sda_pull  (sda_pull_o),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .ptr       (ptr),
        .auto_inc  (auto_inc)
    );

    acp_ctrl_regs #(.NUM(NUM_CTRL), .DW(BYTE_W), .PW(PTR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .regs_o  (regs)
    );

    assign src_sel_o  = regs[IDX_SRC_SEL];
    assign src_gain_o = regs[IDX_SRC_GAIN];
    assign volume_o   = regs[IDX_VOLUME];
    assign bass_o     = regs[IDX_BASS];
    assign middle_o   = regs[IDX_MIDDLE];
    assign treble_o   = regs[IDX_TREBLE];
    assign spk_r_o    = regs[IDX_SPK_R];
    assign spk_l_o    = regs[IDX_SPK_L];

    // Decoded flags for the analog side
    assign vol_mute_o    = (volume_o[5:4] == 2'b11);
    assign spk_r_mute_o  = (spk_r_o[6:3] >= SPK_MUTE_MIN);
    assign spk_l_mute_o  = (spk_l_o[6:3] >= SPK_MUTE_MIN);
    assign src_sel_bad_o = (src_sel_o[1:0] == 2'b01);

endmodule

// File: rtl/acp_i2c_checker.sv
module acp_i2c_checker
    import acp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start_det,
    input logic             stop_det,
    input logic             scl_fall,
    input bus_state_e       bus_state,
    input logic             sda_pull_o,
    input logic             wr_en,
    input logic [PTR_W-1:0] wr_idx,
    input logic [PTR_W-1:0] ptr,
    input logic             auto_inc,
    input logic [7:0]       src_sel_o,
    input logic [7:0]       src_gain_o,
    input logic [7:0]       volume_o,
    input logic [7:0]       bass_o,
    input logic [7:0]       middle_o,
    input logic [7:0]       treble_o,
    input logic [7:0]       spk_r_o,
    input logic [7:0]       spk_l_o
);

    logic [63:0] all_regs;
    logic        in_ack;

    assign all_regs = {src_sel_o, src_gain_o, volume_o, bass_o,
                       middle_o, treble_o, spk_r_o, spk_l_o};
    assign in_ack   = (bus_state == ST_ADDR_ACK) || (bus_state == ST_SUB_ACK) ||
                      (bus_state == ST_DATA_ACK);

    AST_START_ENTERS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (bus_state == ST_ADDR)); // R1

    AST_STOP_ENTERS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (bus_state == ST_IDLE)); // R1

    AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack && scl_fall) |=> !sda_pull_o); // R2

    AST_PULL_ONLY_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull_o |-> in_ack); // R2

    AST_IGNORED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == ST_IGNORE) |-> !sda_pull_o); // R3

    AST_FIXED_POINTER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !auto_inc) |-> (ptr == wr_idx)); // R5

    AST_POINTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && auto_inc) |-> (ptr == PTR_W'(wr_idx + 1'b1))); // R6

    AST_HIGH_INDEX_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx[PTR_W-1]) |=> $stable(all_regs)); // R7

    AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (all_regs == 64'h020E_380F_0E0E_7878)); // R8

endmodule

bind acp_i2c_target acp_i2c_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .scl_fall   (scl_fall),
    .bus_state  (bus_state),
    .sda_pull_o (sda_pull_o),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .ptr        (ptr),
    .auto_inc   (auto_inc),
    .src_sel_o  (src_sel_o),
    .src_gain_o (src_gain_o),
    .volume_o   (volume_o),
    .bass_o     (bass_o),
    .middle_o   (middle_o),
    .treble_o   (treble_o),
    .spk_r_o    (spk_r_o),
    .spk_l_o    (spk_l_o)
);

// File: tb/acp_i2c_target_tb_top.sv
`timescale 1ns/1ps
module acp_i2c_target_tb_top;

    localparam int Q = 10;          // system clocks per quarter SCL bit
    localparam int SETTLE_NS = 100; // quiet time before per-clock compare

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_bus;

    logic       sda_pull_o;
    logic [7:0] src_sel_o, src_gain_o, volume_o, bass_o;
    logic [7:0] middle_o, treble_o, spk_r_o, spk_l_o;
    logic       vol_mute_o, spk_r_mute_o, spk_l_mute_o, src_sel_bad_o;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 1'b0;
    time last_mark = 0;
    string cur_tag = "R8";

    logic [7:0] exp_reg [8];
    logic       exp_pull = 1'b0;
    logic [7:0] act [8];

    always #5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull_o;

    acp_i2c_target dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_m),
        .sda_i         (sda_bus),
        .sda_pull_o    (sda_pull_o),
        .src_sel_o     (src_sel_o),
        .src_gain_o    (src_gain_o),
        .volume_o      (volume_o),
        .bass_o        (bass_o),
        .middle_o      (middle_o),
        .treble_o      (treble_o),
        .spk_r_o       (spk_r_o),
        .spk_l_o       (spk_l_o),
        .vol_mute_o    (vol_mute_o),
        .spk_r_mute_o  (spk_r_mute_o),
        .spk_l_mute_o  (spk_l_mute_o),
        .src_sel_bad_o (src_sel_bad_o)
    );

    always_comb begin
        act[0] = src_sel_o; act[1] = src_gain_o; act[2] = volume_o; act[3] = bass_o;
        act[4] = middle_o;  act[5] = treble_o;   act[6] = spk_r_o;  act[7] = spk_l_o;
    end

    // Reference model: flags decoded from the expected registers per R9..R11
    function automatic bit mdl_vol_mute();
        return exp_reg[2][5] && exp_reg[2][4];
    endfunction
    function automatic bit mdl_spk_mute(input int i);
        return (int'(exp_reg[i][6:3]) >= 10);
    endfunction
    function automatic bit mdl_src_bad();
        return (exp_reg[0][1:0] == 2'b01);
    endfunction

    // Per-clock comparison once the bus has been quiet long enough
    always @(negedge clk) begin
        if (rst_n && !done && (($time - last_mark) > SETTLE_NS)) begin
            bit bad;
            bad = 1'b0;
            vectors++;
            for (int i = 0; i < 8; i++) begin
                if (act[i] !== exp_reg[i]) begin
                    $display("FAIL %s reg%0d actual=%02h expected=%02h", cur_tag, i, act[i], exp_reg[i]);
                    bad = 1'b1;
                end
            end
            if (sda_pull_o !== exp_pull) begin
                $display("FAIL R2 sda_pull actual=%b expected=%b", sda_pull_o, exp_pull);
                bad = 1'b1;
            end
            if (vol_mute_o !== mdl_vol_mute()) begin
                $display("FAIL R9 vol_mute actual=%b expected=%b", vol_mute_o, mdl_vol_mute());
                bad = 1'b1;
            end
            if (spk_r_mute_o !== mdl_spk_mute(6) || spk_l_mute_o !== mdl_spk_mute(7)) begin
                $display("FAIL R10 spk_mute actual=%b%b expected=%b%b", spk_r_mute_o, spk_l_mute_o,
                         mdl_spk_mute(6), mdl_spk_mute(7));
                bad = 1'b1;
            end
            if (src_sel_bad_o !== mdl_src_bad()) begin
                $display("FAIL R11 src_sel_bad actual=%b expected=%b", src_sel_bad_o, mdl_src_bad());
                bad = 1'b1;
            end
            if (bad) miscompares++;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic mark();
        last_mark = $time;
    endtask

    // One data bit; returns right after the SCL falling edge
    task automatic put_bit(input logic b);
        wait_cyc(Q); sda_m = b; mark();
        wait_cyc(Q); scl_m = 1'b1; mark();
        wait_cyc(2*Q); scl_m = 1'b0; mark();
    endtask

    task automatic put_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
    endtask

    // Ninth clock: master releases SDA and checks the target's acknowledge
    task automatic ack_clock(input bit expect_ack, input string tag);
        sda_m = 1'b1; mark();
        wait_cyc(Q); scl_m = 1'b1; mark();
        wait_cyc(Q);
        vectors++;
        if (sda_bus !== !expect_ack) begin
            miscompares++;
            $display("FAIL %s ack sda actual=%b expected=%b", tag, sda_bus, !expect_ack);
        end
        wait_cyc(Q); scl_m = 1'b0; mark();
        exp_pull = 1'b0;
    endtask

    task automatic start_c();
        wait_cyc(Q); sda_m = 1'b1; mark();
        wait_cyc(Q); scl_m = 1'b1; mark();
        wait_cyc(Q); sda_m = 1'b0; mark();
        wait_cyc(Q); scl_m = 1'b0; mark();
        exp_pull = 1'b0;
    endtask

    task automatic stop_c();
        wait_cyc(Q); sda_m = 1'b0; mark();
        wait_cyc(Q); scl_m = 1'b1; mark();
        wait_cyc(Q); sda_m = 1'b1; mark();
        wait_cyc(Q);
    endtask

    // Whole write transfer with the model updated after each byte's 8th bit
    task automatic xfer(input logic [7:0] addr, input logic [7:0] sub,
                        input logic [7:0] data[$], input string tag);
        bit ok;
        int p;
        bit inc;
        cur_tag = tag;
        start_c();
        put_byte(addr);
        ok = (addr == 8'h88);
        exp_pull = ok;
        ack_clock(ok, tag);
        put_byte(sub);
        exp_pull = ok;
        ack_clock(ok, tag);
        p = int'(sub[3:0]);
        inc = sub[4];
        foreach (data[k]) begin
            put_byte(data[k]);
            if (ok) begin
                if (p < 8) exp_reg[p] = data[k];
                exp_pull = 1'b1;
            end
            ack_clock(ok, tag);
            if (ok && inc) p = (p + 1) % 16;
        end
        stop_c();
    endtask

    initial begin
        exp_reg[0] = 8'h02; exp_reg[1] = 8'h0E; exp_reg[2] = 8'h38; exp_reg[3] = 8'h0F;
        exp_reg[4] = 8'h0E; exp_reg[5] = 8'h0E; exp_reg[6] = 8'h78; exp_reg[7] = 8'h78;
        wait_cyc(5);
        rst_n = 1'b1;
        mark();
        // R8: defaults compared by the per-clock model while idle
        wait_cyc(40);

        // R4, R5, R9: don't-care bits set, fixed pointer on volume
        xfer(8'h88, 8'hE2, '{8'h15, 8'h3A}, "R5");
        wait_cyc(20);
        xfer(8'h88, 8'hA2, '{8'h27}, "R4");
        wait_cyc(20);

        // R6, R10, R11: fill all registers with stepping pointer
        xfer(8'h88, 8'h10, '{8'h01, 8'h16, 8'h08, 8'h03, 8'h0C, 8'h09, 8'h50, 8'h48}, "R6");
        wait_cyc(20);

        // R7 and wrap: 14, 15 dropped, then 0 and 1 written
        xfer(8'h88, 8'h1E, '{8'hAA, 8'hBB, 8'h03, 8'h1D}, "R7");
        wait_cyc(20);

        // R7: fixed pointer at a dropped index
        xfer(8'h88, 8'h09, '{8'h11, 8'h22}, "R7");
        wait_cyc(20);

        // R3: foreign address and read form of own address
        xfer(8'h8A, 8'h03, '{8'h55}, "R3");
        wait_cyc(20);
        xfer(8'h89, 8'h02, '{8'h00}, "R3");
        wait_cyc(20);

        // R1: repeated START cuts a data byte short
        cur_tag = "R1";
        start_c();
        put_byte(8'h88); exp_pull = 1'b1; ack_clock(1'b1, "R1");
        put_byte(8'h05); exp_pull = 1'b1; ack_clock(1'b1, "R1");
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        xfer(8'h88, 8'h03, '{8'h0B}, "R1");
        wait_cyc(20);

        // R1: STOP cuts a data byte short
        cur_tag = "R1";
        start_c();
        put_byte(8'h88); exp_pull = 1'b1; ack_clock(1'b1, "R1");
        put_byte(8'h05); exp_pull = 1'b1; ack_clock(1'b1, "R1");
        put_bit(1'b0); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        stop_c();
        wait_cyc(20);

        // R1: clocking in idle after STOP gives no acknowledge and no write
        put_byte(8'h88);
        ack_clock(1'b0, "R1");
        put_byte(8'h00);
        ack_clock(1'b0, "R1");
        wait_cyc(40);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        wait_cyc(150000);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog expired in %s", cur_tag);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule